// File: doc/BRIEF.md
# Comma-Detect Word Boundary Aligner

This block receives a serial bit stream, one bit per clock, and cuts it into 10-bit words. It keeps a running window over the most recent bits and compares the newest seven of them with a comma pattern and with that pattern's bitwise complement. While the alignment enable is high, each comma it finds moves the word boundary. The word that follows then carries the comma in its lowest seven bits, and a flag marks that word.

While the enable is low, the boundary is frozen at the offset that was last in use. Scrambled or otherwise unencoded traffic can then pass through without the boundary jumping whenever a comma-like run appears by chance. After reset the boundary offset is zero: the first word is made of the first ten bits sampled after reset is released. Every word comes with a one-cycle valid strobe.

Top module: `comma_word_aligner`

## Requirements
- R1: While reset is high, and on the first cycle after it, word_vld_o and comma_seen_o are low.
- R2: With no realignment, word_vld_o pulses once every 10 bits. The first pulse comes for the 10th bit after reset release. word_o holds the last ten bits received, with the earliest bit in word_o[0].
- R3: With align_en_i high, the seven-bit sequence 0,0,1,1,1,1,1 (in arrival order, so word_o[6:0] = 7'b1111100 once aligned) realigns the boundary. The next word starts with the comma's first bit, and words then follow every 10 bits.
- R4: The complement sequence 1,1,0,0,0,0,0 (word_o[6:0] = 7'b0000011) realigns the boundary in the same way as R3.
- R5: With align_en_i low, neither sequence changes the word cadence. align_en_i is sampled on the same edge as the bit that completes the sequence.
- R6: comma_seen_o is high together with word_vld_o on exactly the one word that begins with a comma found while alignment was enabled. It is low on every other cycle.
- R7: A comma that already falls at bits 0 to 6 of a word leaves the cadence unchanged.
- R8: word_vld_o rises on the cycle after the edge that sampled a word's last bit. A word whose last bit arrives on the same edge as a comma's last bit is still delivered.
- R9: Asserting reset in the middle of a stream returns the boundary offset to zero, whatever realignment came before.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Bit clock |
| rst_i | input | 1 | Synchronous active-high reset |
| ser_bit_i | input | 1 | Serial data, one bit per clock |
| align_en_i | input | 1 | High lets commas move the word boundary |
| word_o | output | 10 | Aligned word, earliest bit in bit 0 |
| word_vld_o | output | 1 | One-cycle strobe per word |
| comma_seen_o | output | 1 | Marks the word that begins with a detected comma |

## Verification
The hardest cases to reach are those where a comma completes at or just before an old boundary. A word on the old boundary may still be due, or be suppressed, within the three bits before the new boundary takes over. The bench places a comma at each of the ten offsets relative to the reset boundary, in both polarities. It runs every combination of the enable before and after a mid-stream switch, with a second comma of the opposite polarity after the switch. Expected words, strobes and flags are computed from bit indices.

// File: rtl/aw_pkg.sv
package aw_pkg;
    localparam int unsigned AW_WORD_W  = 10;
    localparam int unsigned AW_COMMA_W = 7;
    // Comma in arrival order: bit 0 is the first bit received (0,0,1,1,1,1,1).
    localparam logic [AW_COMMA_W-1:0] AW_COMMA_SEQ = 7'b1111100;
endpackage

// File: rtl/aw_window.sv
module aw_window #(
    parameter int unsigned            WORD_W    = aw_pkg::AW_WORD_W,
    parameter int unsigned            COMMA_W   = aw_pkg::AW_COMMA_W,
    parameter logic [COMMA_W-1:0]     COMMA_SEQ = aw_pkg::AW_COMMA_SEQ
) (
    input  logic              clk_i,
    input  logic              rst_i,
    input  logic              ser_bit_i,
    input  logic              align_en_i,
    output logic [WORD_W-1:0] win_next_o,
    output logic              hit_o
);
    localparam int unsigned HIST_W = WORD_W - 1;
    localparam int unsigned NPOL   = 2;

    typedef struct packed {
        logic [HIST_W-1:0] hist;
    } win_state_t;

    win_state_t        s_d, s_q;
    logic [WORD_W-1:0] win_d;
    logic [NPOL-1:0]   pol_match_d;

    always_comb begin
        win_d      = {ser_bit_i, s_q.hist};
        s_d        = s_q;
        s_d.hist   = win_d[WORD_W-1:1];
        win_next_o = win_d;
    end

    // Polarity 0 is the comma itself, polarity 1 its complement.
    for (genvar g = 0; g < NPOL; g++) begin : g_pol
        localparam logic [COMMA_W-1:0] PAT = (g == 0) ? COMMA_SEQ : ~COMMA_SEQ;
        assign pol_match_d[g] = (win_d[WORD_W-1 -: COMMA_W] == PAT);
    end

    assign hit_o = align_en_i && (|pol_match_d);

    always_ff @(posedge clk_i) begin
        if (rst_i) s_q <= '0;
        else       s_q <= s_d;
    end
endmodule

// File: rtl/aw_boundary.sv
module aw_boundary #(
    parameter int unsigned WORD_W  = aw_pkg::AW_WORD_W,
    parameter int unsigned COMMA_W = aw_pkg::AW_COMMA_W
) (
    input  logic              clk_i,
    input  logic              rst_i,
    input  logic              hit_i,
    input  logic [WORD_W-1:0] win_i,
    output logic [WORD_W-1:0] word_o,
    output logic              valid_o,
    output logic              comma_o
);
    localparam int unsigned REM_W = $clog2(WORD_W);
    localparam logic [REM_W-1:0] RELOAD    = REM_W'(WORD_W - 1);
    localparam logic [REM_W-1:0] ALIGN_REM = REM_W'(WORD_W - COMMA_W - 1);

    typedef struct packed {
        logic [REM_W-1:0]  rem;
        logic              pend;
        logic [WORD_W-1:0] word;
        logic              valid;
        logic              comma;
    } bnd_state_t;

    bnd_state_t s_d, s_q;

    always_comb begin
        s_d       = s_q;
        s_d.valid = 1'b0;
        s_d.comma = 1'b0;
        if (s_q.rem == '0) begin
            s_d.word  = win_i;
            s_d.valid = 1'b1;
            s_d.comma = s_q.pend;
            s_d.pend  = 1'b0;
            s_d.rem   = RELOAD;
        end else begin
            s_d.rem   = s_q.rem - 1'b1;
        end
        if (hit_i) begin
            s_d.rem  = ALIGN_REM;
            s_d.pend = 1'b1;
        end
    end

    always_ff @(posedge clk_i) begin
        if (rst_i) begin
            s_q     <= '0;
            s_q.rem <= RELOAD;
        end else begin
            s_q <= s_d;
        end
    end

    assign word_o  = s_q.word;
    assign valid_o = s_q.valid;
    assign comma_o = s_q.comma;

    assert_reset_state_R1: assert property (@(posedge clk_i)
        rst_i |=> (!s_q.valid && !s_q.comma && s_q.rem == RELOAD));

    assert_realign_R3: assert property (@(posedge clk_i) disable iff (rst_i)
        hit_i |=> (s_q.rem == ALIGN_REM && s_q.pend));

    assert_fixed_cadence_R5: assert property (@(posedge clk_i) disable iff (rst_i)
        (!hit_i && s_q.rem != '0) |=> (s_q.rem == REM_W'($past(s_q.rem) - 1'b1) && !s_q.valid));

    assert_word_wrap_R2: assert property (@(posedge clk_i) disable iff (rst_i)
        (!hit_i && s_q.rem == '0) |=> (s_q.rem == RELOAD && s_q.valid));
endmodule

// File: rtl/comma_word_aligner.sv
module comma_word_aligner #(
    parameter int unsigned        WORD_W    = aw_pkg::AW_WORD_W,
    parameter int unsigned        COMMA_W   = aw_pkg::AW_COMMA_W,
    parameter logic [COMMA_W-1:0] COMMA_SEQ = aw_pkg::AW_COMMA_SEQ
) (
    input  logic              clk_i,
    input  logic              rst_i,
    input  logic              ser_bit_i,
    input  logic              align_en_i,
    output logic [WORD_W-1:0] word_o,
    output logic              word_vld_o,
    output logic              comma_seen_o
);
    logic [WORD_W-1:0] win_next;
    logic              hit;

    aw_window #(
        .WORD_W   (WORD_W),
        .COMMA_W  (COMMA_W),
        .COMMA_SEQ(COMMA_SEQ)
    ) u_window (
        .clk_i     (clk_i),
        .rst_i     (rst_i),
        .ser_bit_i (ser_bit_i),
        .align_en_i(align_en_i),
        .win_next_o(win_next),
        .hit_o     (hit)
    );

    aw_boundary #(
        .WORD_W (WORD_W),
        .COMMA_W(COMMA_W)
    ) u_boundary (
        .clk_i  (clk_i),
        .rst_i  (rst_i),
        .hit_i  (hit),
        .win_i  (win_next),
        .word_o (word_o),
        .valid_o(word_vld_o),
        .comma_o(comma_seen_o)
    );

    // The flagged word must carry a comma of either polarity in its low bits.
    assert_flag_aligned_R6: assert property (@(posedge clk_i) disable iff (rst_i)
        comma_seen_o |-> (word_vld_o &&
            (word_o[COMMA_W-1:0] == COMMA_SEQ || word_o[COMMA_W-1:0] == ~COMMA_SEQ)));
endmodule

// File: tb/comma_word_aligner_bench.sv
module comma_word_aligner_bench;
    localparam int W = 10;

    logic         clk = 1'b0;
    logic         rst;
    logic         ser_bit;
    logic         align_en;
    logic [W-1:0] word;
    logic         word_vld;
    logic         comma_seen;

    int checks = 0;
    int errors = 0;
    int cycles = 0;

    always #2 clk = ~clk;

    comma_word_aligner u_comma_word_aligner (
        .clk_i       (clk),
        .rst_i       (rst),
        .ser_bit_i   (ser_bit),
        .align_en_i  (align_en),
        .word_o      (word),
        .word_vld_o  (word_vld),
        .comma_seen_o(comma_seen)
    );

    function automatic logic comma_bit(int k, bit pol);
        return logic'(k >= 2) ^ logic'(pol);
    endfunction

    // Alternating filler never holds five equal bits in a row, so no stray comma.
    function automatic logic sbit(int n, int p, int q, bit pol);
        if (n >= p && n < p + 7) return comma_bit(n - p, pol);
        if (n >= q && n < q + 7) return comma_bit(n - q, !pol);
        return logic'(n % 2);
    endfunction

    task automatic chk(bit ok, string tag, string what, int act, int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s: actual %0h expected %0h", tag, what, act, exp);
        end
    endtask

    task automatic run(int off, bit pol, bit d1, bit d2);
        int           p;
        int           q;
        int           len;
        int           next_e;
        int           flag_at;
        bit           exp_v;
        bit           exp_c;
        bit           dn;
        logic [W-1:0] exp_w;
        string        tag;
        p       = 10 + off;
        q       = p + 23;
        len     = q + 30;
        next_e  = 9;
        flag_at = -1;
        if (!d1)          tag = "R5";
        else if (off == 0) tag = "R7";
        else if (pol)     tag = "R4";
        else              tag = "R3";
        rst      = 1'b1;
        ser_bit  = 1'b0;
        align_en = 1'b0;
        repeat (2) @(negedge clk);
        chk(!word_vld && !comma_seen, "R1 R9", "outputs in reset",
            {word_vld, comma_seen}, 0);
        rst = 1'b0;
        for (int n = 0; n < len; n++) begin
            dn       = (n < p + 12) ? d1 : d2;
            ser_bit  = sbit(n, p, q, pol);
            align_en = dn;
            @(negedge clk);
            exp_v = (n == next_e);
            if (exp_v) next_e += 10;
            exp_c = exp_v && (n == flag_at);
            if (dn && (n == p + 6 || n == q + 6)) begin
                next_e  = n + 3;
                flag_at = n + 3;
            end
            chk(word_vld == exp_v, {tag, " R8"}, $sformatf("valid at bit %0d", n),
                word_vld, exp_v);
            chk(comma_seen == exp_c, "R6", $sformatf("comma flag at bit %0d", n),
                comma_seen, exp_c);
            if (exp_v && word_vld) begin
                for (int i = 0; i < W; i++) exp_w[i] = sbit(n - 9 + i, p, q, pol);
                chk(word == exp_w, "R2", $sformatf("word at bit %0d", n), word, exp_w);
            end
        end
    endtask

    initial begin
        for (int off = 0; off < 10; off++)
            for (int pol = 0; pol < 2; pol++)
                for (int m = 0; m < 4; m++)
                    run(off, pol[0], m[1], m[0]);
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    always @(posedge clk) begin
        cycles++;
        if (cycles > 150000) begin
            checks++;
            errors++;
            $display("FAIL watchdog: actual %0d cycles expected completion", cycles);
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end
endmodule